// File: doc/BRIEF.md
# Adaptive Threshold R-Peak Detector

This block watches a stream of 16-bit unsigned ECG samples and reports each R-peak it finds. Samples arrive one per `sample_valid` tick, at a nominal 2 kHz. Clock cycles without a tick leave the block unchanged. After reset the block spends a fixed learning window recording the smallest and largest sample. From those two values it sets a starting threshold, and it then hunts for samples above that threshold.

Inside a burst above threshold, the largest sample becomes the peak candidate. The candidate is accepted only if no larger sample appears in the next eight ticks. Every peak is therefore reported with the same fixed delay after its highest sample. On acceptance the block raises `trigger` for one clock, stores the peak, and moves the threshold toward the new peak. It then waits for the signal to fall back to or below the threshold before it will look for another peak. This stops one QRS complex from firing twice.

Top module: `hrp_peak_detector`

## Requirements
- R1: While `rst` is high, and on the clock after it is released, `trigger` is 0, `threshold` is 0 and `peak_value` is 0.
- R2: No trigger is produced during the first SETUP_TICKS (default 2000) valid ticks after reset, whatever the sample values.
- R3: On the clock after the last learning tick, `threshold` equals lo + (d>>1) + (d>>2), where lo and hi are the extremes over all learning samples and d = hi - lo. When all learning samples are equal, the threshold equals that value.
- R4: A sample equal to or below `threshold` never starts a peak candidate.
- R5: A sample above the threshold becomes the candidate. If the next VERIFY_TICKS (default 8) ticks bring no larger sample, `trigger` is 1 on the clock after the eighth of those ticks, and never earlier. At that point `peak_value` holds the candidate, which exceeds the new threshold.
- R6: A larger sample arriving during verification replaces the candidate and restarts the tick count from zero.
- R7: On the clock where `trigger` is 1, `threshold` becomes (old>>1) + (peak>>2) + (peak>>3), saturated to all ones.
- R8: After a trigger, samples above the threshold are ignored until one sample at or below the threshold has been seen.
- R9: A clock with `sample_valid` low changes neither the outputs nor any count, whatever the value on `sample`.
- R10: `trigger` is high for exactly one clock per confirmed peak.
- R11: A synchronous reset in the middle of operation restarts the learning window with cleared extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | High for one clock when `sample` holds a new ECG sample |
| sample | input | 16 | Unsigned ECG sample |
| trigger | output | 1 | One-clock pulse per confirmed R-peak |
| threshold | output | 16 | Current detection threshold |
| peak_value | output | 16 | Amplitude of the most recently confirmed peak |

## Verification
The assertions assume that `rst` is high from time zero for at least one clock. They also assume that `sample` is ignored on every clock where `sample_valid` is low, so no property depends on the value present then. The stimulus drives garbage samples (60000) in those gaps to show they have no effect. It places every sample exactly at, or one above, the current threshold where the comparison direction matters. Learning windows use either one high and one low outlier or a constant value, so the expected threshold is exact arithmetic.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {
    ST_SETUP   = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_TRACK   = 2'd2,
    ST_HOLDOFF = 2'd3
  } hrp_state_e;
endpackage

// File: rtl/hrp_range_learn.sv
module hrp_range_learn #(
  parameter int W           = 16,
  parameter int SETUP_TICKS = 2000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         learn_en,
  input  logic [W-1:0] sample,
  output logic         learn_done,
  output logic [W-1:0] init_thr
);
  localparam int CW = (SETUP_TICKS > 1) ? $clog2(SETUP_TICKS) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  lo_q, hi_q, lo_n, hi_n, span;

  assign lo_n = (sample < lo_q) ? sample : lo_q;
  assign hi_n = (sample > hi_q) ? sample : hi_q;
  assign span = hi_n - lo_n;
  // lo + 3/4 of span, built from two shifts; never exceeds hi_n
  assign init_thr   = lo_n + (span >> 1) + (span >> 2);
  assign learn_done = learn_en && (cnt_q == CW'(SETUP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lo_q  <= '1;
      hi_q  <= '0;
    end else if (learn_en) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      if (!learn_done) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hrp_candidate.sv
module hrp_candidate #(
  parameter int W            = 16,
  parameter int VERIFY_TICKS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         trk_tick,
  input  logic [W-1:0] sample,
  output logic [W-1:0] cand,
  output logic         confirm
);
  localparam int CW = (VERIFY_TICKS > 1) ? $clog2(VERIFY_TICKS) : 1;

  logic [CW-1:0] hold_q;
  logic [W-1:0]  cand_q;
  logic          bigger;

  assign bigger  = sample > cand_q;
  assign cand    = cand_q;
  assign confirm = trk_tick && !bigger && (hold_q == CW'(VERIFY_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      hold_q <= '0;
    end else if (start) begin
      cand_q <= sample;
      hold_q <= '0;
    end else if (trk_tick) begin
      if (bigger) begin
        cand_q <= sample;
        hold_q <= '0;
      end else if (!confirm) begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hrp_thr_update.sv
module hrp_thr_update #(
  parameter int W = 16
) (
  input  logic [W-1:0] thr_old,
  input  logic [W-1:0] peak,
  output logic [W-1:0] thr_new
);
  logic [W:0] sum;

  // half of old threshold plus three eighths of the peak
  assign sum = {1'b0, thr_old >> 1} + {1'b0, peak >> 2} + {1'b0, peak >> 3};
  assign thr_new = sum[W] ? {W{1'b1}} : sum[W-1:0];
endmodule

// File: rtl/hrp_peak_detector.sv
module hrp_peak_detector
  import hrp_pkg::*;
#(
  parameter int W            = 16,
  parameter int SETUP_TICKS  = 2000,
  parameter int VERIFY_TICKS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_valid,
  input  logic [W-1:0] sample,
  output logic         trigger,
  output logic [W-1:0] threshold,
  output logic [W-1:0] peak_value
);
  hrp_state_e   state_q;
  logic [W-1:0] thr_q, peak_q, init_thr, cand, thr_next;
  logic         trig_q, learn_en, learn_done, start, trk_tick, confirm;

  assign learn_en = sample_valid && (state_q == ST_SETUP);
  assign start    = sample_valid && (state_q == ST_SEARCH) && (sample > thr_q);
  assign trk_tick = sample_valid && (state_q == ST_TRACK);

  hrp_range_learn #(.W(W), .SETUP_TICKS(SETUP_TICKS)) u_learn (
    .clk(clk), .rst(rst), .learn_en(learn_en), .sample(sample),
    .learn_done(learn_done), .init_thr(init_thr)
  );

  hrp_candidate #(.W(W), .VERIFY_TICKS(VERIFY_TICKS)) u_cand (
    .clk(clk), .rst(rst), .start(start), .trk_tick(trk_tick),
    .sample(sample), .cand(cand), .confirm(confirm)
  );

  hrp_thr_update #(.W(W)) u_upd (
    .thr_old(thr_q), .peak(cand), .thr_new(thr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SETUP;
      thr_q   <= '0;
      peak_q  <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      case (state_q)
        ST_SETUP: if (learn_done) begin
          thr_q   <= init_thr;
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: if (start) state_q <= ST_TRACK;
        ST_TRACK: if (confirm) begin
          trig_q  <= 1'b1;
          peak_q  <= cand;
          thr_q   <= thr_next;
          state_q <= ST_HOLDOFF;
        end
        ST_HOLDOFF: if (sample_valid && (sample <= thr_q)) state_q <= ST_SEARCH;
        default: state_q <= ST_SETUP;
      endcase
    end
  end

  assign trigger    = trig_q;
  assign threshold  = thr_q;
  assign peak_value = peak_q;
endmodule

// File: rtl/hrp_peak_checker.sv
module hrp_peak_checker #(
  parameter int W           = 16,
  parameter int SETUP_TICKS = 2000
) (
  input logic         clk,
  input logic         rst,
  input logic         sample_valid,
  input logic         trigger,
  input logic [W-1:0] threshold,
  input logic [W-1:0] peak_value
);
  localparam int SW = $clog2(SETUP_TICKS + 1);

  logic [SW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (sample_valid && (seen_q != SW'(SETUP_TICKS))) seen_q <= seen_q + 1'b1;
  end

  function automatic logic [W-1:0] exp_thr(input logic [W-1:0] o, input logic [W-1:0] p);
    logic [W:0] s;
    s = {1'b0, o >> 1} + {1'b0, p >> 2} + {1'b0, p >> 3};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!trigger && threshold == '0 && peak_value == '0));

  // R2
  no_setup_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q < SW'(SETUP_TICKS)) |-> !trigger);

  // R5
  peak_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |-> (peak_value > threshold));

  // R7
  thr_update_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |-> (threshold == exp_thr($past(threshold), peak_value)));

  // R9
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> (!trigger && $stable(threshold) && $stable(peak_value)));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |=> !trigger);
endmodule

bind hrp_peak_detector hrp_peak_checker #(.W(W), .SETUP_TICKS(SETUP_TICKS)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid),
  .trigger(trigger), .threshold(threshold), .peak_value(peak_value)
);

// File: tb/hrp_peak_detector_test.sv
module hrp_peak_detector_test;
  localparam int W = 16;
  localparam int SETUP = 2000;

  logic clk = 1'b0, rst = 1'b1, sample_valid = 1'b0;
  logic [W-1:0] sample = '0;
  logic trigger;
  logic [W-1:0] threshold, peak_value;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  hrp_peak_detector #(.W(W), .SETUP_TICKS(SETUP), .VERIFY_TICKS(8)) uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
    .trigger(trigger), .threshold(threshold), .peak_value(peak_value)
  );

  // {valid, sample, exp trigger, exp threshold, exp peak}; threshold starts at 7000
  localparam int NV = 28;
  localparam logic [49:0] VECS [NV] = '{
    {1'b1, 16'd7000, 1'b0, 16'd7000, 16'd0},    // R4 equal is ignored
    {1'b1, 16'd6000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd8000, 1'b0, 16'd7000, 16'd0},    // candidate
    {1'b1, 16'd7500, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd8500, 1'b0, 16'd7000, 16'd0},    // R6 restart
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b0, 16'd7000, 16'd0},
    {1'b1, 16'd5000, 1'b1, 16'd6687, 16'd8500}, // R5 R7
    {1'b1, 16'd9000, 1'b0, 16'd6687, 16'd8500}, // R8 R10
    {1'b1, 16'd8000, 1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd6687, 1'b0, 16'd6687, 16'd8500}, // rearm
    {1'b1, 16'd6688, 1'b0, 16'd6687, 16'd8500}, // candidate
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b0, 16'd60000, 1'b0, 16'd6687, 16'd8500}, // R9
    {1'b0, 16'd60000, 1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b0, 16'd60000, 1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b0, 16'd6687, 16'd8500},
    {1'b1, 16'd100,  1'b1, 16'd5851, 16'd6688}  // R5 R7
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] s);
    sample_valid = v;
    sample = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic learn(input int mode, output int bad);
    bad = 0;
    for (int i = 0; i < SETUP; i++) begin
      logic [W-1:0] s;
      s = (mode == 0) ? ((i == 100) ? 16'd9000 : (i == 200) ? 16'd1000 : 16'd5000) : 16'd20000;
      step(1'b1, s);
      if (i < SETUP - 1 && (trigger || threshold != 0)) bad++;
      if (trigger) bad++;
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!trigger && threshold == 0 && peak_value == 0, "R1 reset", threshold, 0);
    rst = 1'b0;

    // R2 R3 learning with one high and one low outlier
    learn(0, bad);
    chk(bad == 0, "R2 quiet learning", bad, 0);
    chk(threshold == 7000, "R3 initial threshold", threshold, 7000);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k][49], VECS[k][48:33]);
      chk(trigger == VECS[k][32], $sformatf("row %0d trigger (R4 R5 R6 R8 R9 R10)", k),
          trigger, VECS[k][32]);
      chk(threshold == VECS[k][31:16], $sformatf("row %0d threshold (R7)", k),
          threshold, VECS[k][31:16]);
      chk(peak_value == VECS[k][15:0], $sformatf("row %0d peak (R5)", k),
          peak_value, VECS[k][15:0]);
    end

    // R11 mid-run reset
    rst = 1'b1;
    step(1'b1, 16'd60000);
    step(1'b1, 16'd60000);
    chk(!trigger && threshold == 0 && peak_value == 0, "R11 reset mid-run", threshold, 0);
    rst = 1'b0;

    // R3 flat learning window gives threshold equal to the level
    learn(1, bad);
    chk(bad == 0, "R2 R11 quiet relearning", bad, 0);
    chk(threshold == 20000, "R3 flat threshold", threshold, 20000);

    // R4 samples equal to threshold never start a candidate
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 16'd20000);
      if (trigger) bad++;
    end
    chk(bad == 0, "R4 equal samples", bad, 0);

    // R5 exact latency boundary
    step(1'b1, 16'd20001);
    bad = 0;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 16'd0);
      if (trigger) bad++;
    end
    chk(bad == 0, "R5 no early trigger", bad, 0);
    step(1'b1, 16'd0);
    chk(trigger == 1'b1, "R5 trigger on eighth tick", trigger, 1);
    chk(peak_value == 20001, "R5 peak value", peak_value, 20001);
    chk(threshold == 17500, "R7 updated threshold", threshold, 17500);
    step(1'b1, 16'd0);
    chk(trigger == 1'b0, "R10 pulse width", trigger, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule